// File: doc/BRIEF.md
# DRAM Command Decoder and Bank State Tracker

This block watches the command pins of a double-data-rate DRAM interface, as a memory controller or a bus monitor would. On every clock it samples chip select, the row, column and write strobes, clock enable, a 3-bit bank address and address bit 10. It then reports which command was issued, which bank it names, and whether that command is legal given the state of the banks.

Eight bank state machines follow each bank through its life: idle, opening a row, row open, read burst, write burst, write recovery, closing (precharge) and refresh. Row-open delay, precharge time, refresh time, write recovery and burst length are parameters counted in clocks, and the banks leave their timed states on their own. Each command is checked against a legality table. The table looks at the addressed bank, and for the all-bank commands it looks at every bank. A command found illegal is reported but leaves every bank as it was.

Outputs for a command sampled at clock edge N are valid between edges N and N+1. Any bank state change that the command causes is visible after edge N+1.

Top module: `dram_cmd_tracker`

## Requirements
- R1: Command codes on `cmd_o`: 0 deselect, 1 no-op, 2 activate, 3 read, 4 read with auto-precharge, 5 write, 6 write with auto-precharge, 7 single-bank precharge, 8 precharge-all, 9 auto refresh, 10 self-refresh entry, 11 mode-register write, 12 power-down entry, 13 clock-enable hold. With chip select low, the row/column/write strobes decode as: L,H,H activate; H,L,H read; H,L,L write; L,H,L precharge; L,L,H refresh; L,L,L mode-register write; H,H,H no-op.
- R2: Chip select high decodes as deselect whatever the other command inputs are. Deselect and no-op are always legal.
- R3: On read and write, `a10` high selects the auto-precharge variant. On precharge, `a10` high gives precharge-all, and `a10` low closes only the bank on `ba`, leaving other banks untouched.
- R4: Refresh with clock enable sampled high in both the previous and the current cycle is auto refresh. Refresh with clock enable falling is self-refresh entry. Deselect or no-op with clock enable falling is power-down entry. Any sample taken after a low clock-enable sample decodes as hold and is legal. Any other command issued while clock enable falls is decoded by type but flagged illegal.
- R5: Bank states on `bank_state_o[3*i+:3]`: 0 idle, 1 activating, 2 active, 3 reading, 4 writing, 5 write recovery, 6 precharging, 7 refreshing. On an idle bank, read and write are illegal and precharge is a legal no-op. Activate moves the bank to activating, and the bank becomes active T_RCD clocks after the activate, so a read T_RCD clocks after the activate is legal and one a clock earlier is not.
- R6: On an active bank, read and write are legal. Activate, auto refresh and mode-register write are illegal.
- R7: Precharge is illegal on a bank that is activating, in a burst or in write recovery. Precharge-all is legal only when every bank is idle, active or precharging, and it closes every active bank. A precharging bank becomes idle T_RP clocks after the command, and activate on it is illegal before then.
- R8: Auto refresh, self-refresh entry, mode-register write and power-down entry are legal only when all banks are idle. An accepted auto refresh puts all banks in refreshing for T_RFC clocks. Commands other than deselect, no-op and hold that address a refreshing bank are illegal.
- R9: During a read burst a new read to that bank is legal and restarts the burst, and a write is illegal. During a write burst a new write is legal and restarts the burst, and a read is illegal. No interruption is allowed once auto-precharge is pending.
- R10: A burst lasts BURST_LEN/2 clocks from its last command. A read burst then returns to active. A write burst enters write recovery for T_WR clocks, then returns to active. With auto-precharge pending, the bank goes to precharging instead of active, and becomes idle T_RP clocks later.
- R11: An illegal command changes no bank state.
- R12: During and right after reset, `cmd_o` reads deselect, `illegal_o` is low and all banks are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W (3) | Bank address |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-bank select) |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_o | output | BA_W (3) | Bank named by the sampled command |
| illegal_o | output | 1 | Command is illegal in the current bank state |
| bank_state_o | output | 3*NUM_BANKS (24) | State of every bank, 3 bits per bank (R5) |

## Verification
The assertions assume that every command input carries a known 0 or 1 at each rising edge after reset. They also assume that the timing parameters are at least 2 and the burst length at least 4, so every timed state holds for at least one clock. The bench drives all inputs on falling edges with fixed values, keeps clock enable high except in the scenarios that exercise it, and holds reset for several edges with deselect on the pins. Every bank timing check is placed at the exact clock where the requirement says the state changes, so a timer off by one clock in either direction shows up.

// File: rtl/dct_pkg.sv
// Shared types for the DRAM command decoder and bank tracker.
// Assumes: command codes and bank state codes are fixed by the brief (R1, R5).
package dct_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL  = 4'd0,
        CMD_NOP    = 4'd1,
        CMD_ACT    = 4'd2,
        CMD_RD     = 4'd3,
        CMD_RDA    = 4'd4,
        CMD_WR     = 4'd5,
        CMD_WRA    = 4'd6,
        CMD_PRE    = 4'd7,
        CMD_PREALL = 4'd8,
        CMD_AREF   = 4'd9,
        CMD_SREF   = 4'd10,
        CMD_MRS    = 4'd11,
        CMD_PDN    = 4'd12,
        CMD_HOLD   = 4'd13
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE   = 3'd0,
        BK_OPEN   = 3'd1,
        BK_ACTIVE = 3'd2,
        BK_RD     = 3'd3,
        BK_WR     = 3'd4,
        BK_WREC   = 3'd5,
        BK_CLOSE  = 3'd6,
        BK_REF    = 3'd7
    } bank_state_e;

endpackage

// File: rtl/dct_sampler.sv
// Input sampling stage: registers the command pins once per clock and keeps
// the clock-enable value of the previous sample.
// Assumes: the pins are synchronous to clk; reset parks the stage on deselect
// with clock enable high.
module dct_sampler #(
    parameter int BA_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            s_cs_n,
    output logic [2:0]      s_rcw,
    output logic            s_cke,
    output logic            s_cke_prev,
    output logic [BA_W-1:0] s_ba,
    output logic            s_a10
);

    // Capture the pins, and shift clock enable through a two-deep history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_cs_n     <= 1'b1;
            s_rcw      <= 3'b111;
            s_cke      <= 1'b1;
            s_cke_prev <= 1'b1;
            s_ba       <= '0;
            s_a10      <= 1'b0;
        end else begin
            s_cs_n     <= cs_n;
            s_rcw      <= {ras_n, cas_n, we_n};
            s_cke      <= cke;
            s_cke_prev <= s_cke;
            s_ba       <= ba;
            s_a10      <= a10;
        end
    end

endmodule

// File: rtl/dct_decoder.sv
// Command decoder: turns one sampled set of command pins into a command code.
// It also reports a command issued while clock enable falls that is not one of
// the clock-enable transitions.
// Assumes: inputs come from dct_sampler; purely combinational.
module dct_decoder
    import dct_pkg::*;
(
    input  logic       s_cs_n,
    input  logic [2:0] s_rcw,
    input  logic       s_cke,
    input  logic       s_cke_prev,
    input  logic       s_a10,
    output cmd_e       cmd,
    output logic       cke_misuse
);

    // Map strobes, clock-enable history and a10 to a command code.
    always_comb begin
        cmd        = CMD_DESEL;
        cke_misuse = 1'b0;
        if (!s_cke_prev) begin
            cmd = CMD_HOLD;
        end else if (s_cs_n || s_rcw == 3'b111) begin
            if (!s_cke)      cmd = CMD_PDN;
            else if (s_cs_n) cmd = CMD_DESEL;
            else             cmd = CMD_NOP;
        end else begin
            unique case (s_rcw)
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = s_a10 ? CMD_RDA : CMD_RD;
                3'b100:  cmd = s_a10 ? CMD_WRA : CMD_WR;
                3'b010:  cmd = s_a10 ? CMD_PREALL : CMD_PRE;
                3'b001:  cmd = s_cke ? CMD_AREF : CMD_SREF;
                default: cmd = CMD_MRS;
            endcase
            cke_misuse = !s_cke && (s_rcw != 3'b001);
        end
    end

endmodule

// File: rtl/dct_bank.sv
// One bank state machine with its own down-counter. A start pulse loads a
// new state, count and auto-precharge flag. Otherwise, timed states advance
// by themselves when the count runs out.
// Assumes: loaded counts are at least 1; T_RP and T_WR are at least 2.
module dct_bank
    import dct_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int T_RP  = 3,
    parameter int T_WR  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  bank_state_e      start_state_i,
    input  logic [CNT_W-1:0] start_cnt_i,
    input  logic             start_ap_i,
    output bank_state_e      state_o,
    output logic             ap_o
);

    localparam logic [CNT_W-1:0] LD_RP = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] LD_WR = CNT_W'(T_WR);

    logic [CNT_W-1:0] cnt;
    logic             timed;

    // A state is timed when it ends by itself.
    assign timed = !(state_o inside {BK_IDLE, BK_ACTIVE});

    // State, counter and auto-precharge flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= BK_IDLE;
            cnt     <= '0;
            ap_o    <= 1'b0;
        end else if (start_i) begin
            state_o <= start_state_i;
            cnt     <= start_cnt_i;
            ap_o    <= start_ap_i;
        end else if (timed && cnt == CNT_W'(1)) begin
            unique case (state_o)
                BK_OPEN:  state_o <= BK_ACTIVE;
                BK_RD: begin
                    state_o <= ap_o ? BK_CLOSE : BK_ACTIVE;
                    cnt     <= LD_RP;
                    ap_o    <= 1'b0;
                end
                BK_WR: begin
                    state_o <= BK_WREC;
                    cnt     <= LD_WR;
                end
                BK_WREC: begin
                    state_o <= ap_o ? BK_CLOSE : BK_ACTIVE;
                    cnt     <= LD_RP;
                    ap_o    <= 1'b0;
                end
                default:  state_o <= BK_IDLE;
            endcase
        end else if (timed) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Idle is left only by opening a row or by refresh.
    assert_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == BK_IDLE |=> state_o inside {BK_IDLE, BK_OPEN, BK_REF});

    // A closing bank can only stay closing or become idle.
    assert_close_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == BK_CLOSE |=> state_o inside {BK_CLOSE, BK_IDLE});

    // A refreshing bank can only stay refreshing or become idle.
    assert_refresh_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == BK_REF |=> state_o inside {BK_REF, BK_IDLE});

    // A write burst always passes through write recovery.
    assert_write_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == BK_WR |=> state_o inside {BK_WR, BK_WREC});

endmodule

// File: rtl/dram_cmd_tracker.sv
// DRAM command decoder and bank tracker top. It samples the command pins,
// decodes them, checks the command against the bank states and starts bank
// state changes for legal commands only.
// Assumes: NUM_BANKS = 2**BA_W; all timing parameters >= 2; BURST_LEN >= 4.
module dram_cmd_tracker
    import dct_pkg::*;
#(
    parameter int BA_W      = 3,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 6,
    parameter int T_WR      = 3,
    parameter int BURST_LEN = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [BA_W-1:0]            ba,
    input  logic                       a10,
    output logic [3:0]                 cmd_o,
    output logic [BA_W-1:0]            bank_o,
    output logic                       illegal_o,
    output logic [3*(2**BA_W)-1:0]     bank_state_o
);

    localparam int NUM_BANKS = 2 ** BA_W;
    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int M_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int M_B   = (T_RFC > T_WR) ? T_RFC : T_WR;
    localparam int M_C   = (M_A > M_B) ? M_A : M_B;
    localparam int T_MAX = (M_C > BURST_CYC) ? M_C : BURST_CYC;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_BUR = CNT_W'(BURST_CYC - 1);

    logic            s_cs_n, s_cke, s_cke_prev, s_a10;
    logic [2:0]      s_rcw;
    logic [BA_W-1:0] s_ba;
    cmd_e            cmd;
    logic            cke_misuse;
    bank_state_e     st [NUM_BANKS];
    logic [NUM_BANKS-1:0] ap;
    logic            all_idle, all_pre_ok, bad, illegal;
    bank_state_e     tgt;
    logic            tgt_ap;

    dct_sampler #(.BA_W(BA_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
        .s_cs_n(s_cs_n), .s_rcw(s_rcw), .s_cke(s_cke), .s_cke_prev(s_cke_prev),
        .s_ba(s_ba), .s_a10(s_a10)
    );

    dct_decoder u_decoder (
        .s_cs_n(s_cs_n), .s_rcw(s_rcw), .s_cke(s_cke), .s_cke_prev(s_cke_prev),
        .s_a10(s_a10), .cmd(cmd), .cke_misuse(cke_misuse)
    );

    // Summaries over all banks used by the all-bank commands.
    always_comb begin
        all_idle   = 1'b1;
        all_pre_ok = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (st[i] != BK_IDLE) all_idle = 1'b0;
            if (!(st[i] inside {BK_IDLE, BK_ACTIVE, BK_CLOSE})) all_pre_ok = 1'b0;
        end
    end

    // Legality table: command against the addressed bank or all banks.
    always_comb begin
        tgt    = st[s_ba];
        tgt_ap = ap[s_ba];
        unique case (cmd)
            CMD_ACT:            bad = (tgt != BK_IDLE);
            CMD_RD, CMD_RDA:    bad = !(tgt == BK_ACTIVE || (tgt == BK_RD && !tgt_ap));
            CMD_WR, CMD_WRA:    bad = !(tgt == BK_ACTIVE ||
                                        ((tgt == BK_WR || tgt == BK_WREC) && !tgt_ap));
            CMD_PRE:            bad = !(tgt inside {BK_IDLE, BK_ACTIVE, BK_CLOSE});
            CMD_PREALL:         bad = !all_pre_ok;
            CMD_AREF, CMD_SREF,
            CMD_MRS, CMD_PDN:   bad = !all_idle;
            default:            bad = 1'b0;
        endcase
        illegal = bad || cke_misuse;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
            logic             go;
            bank_state_e      nst;
            logic [CNT_W-1:0] ld;
            logic             nap;
            logic             hit;

            assign hit = (s_ba == BA_W'(gi));

            // Start request for this bank from a legal command.
            always_comb begin
                go  = 1'b0;
                nst = BK_IDLE;
                ld  = '0;
                nap = 1'b0;
                if (!illegal) begin
                    unique case (cmd)
                        CMD_ACT: if (hit) begin
                            go = 1'b1; nst = BK_OPEN; ld = LD_RCD;
                        end
                        CMD_RD, CMD_RDA: if (hit) begin
                            go = 1'b1; nst = BK_RD; ld = LD_BUR; nap = (cmd == CMD_RDA);
                        end
                        CMD_WR, CMD_WRA: if (hit) begin
                            go = 1'b1; nst = BK_WR; ld = LD_BUR; nap = (cmd == CMD_WRA);
                        end
                        CMD_PRE: if (hit && st[gi] == BK_ACTIVE) begin
                            go = 1'b1; nst = BK_CLOSE; ld = LD_RP;
                        end
                        CMD_PREALL: if (st[gi] == BK_ACTIVE) begin
                            go = 1'b1; nst = BK_CLOSE; ld = LD_RP;
                        end
                        CMD_AREF: begin
                            go = 1'b1; nst = BK_REF; ld = LD_RFC;
                        end
                        default: go = 1'b0;
                    endcase
                end
            end

            dct_bank #(.CNT_W(CNT_W), .T_RP(T_RP), .T_WR(T_WR)) u_bank (
                .clk(clk), .rst_n(rst_n), .start_i(go), .start_state_i(nst),
                .start_cnt_i(ld), .start_ap_i(nap), .state_o(st[gi]), .ap_o(ap[gi])
            );

            assign bank_state_o[3*gi +: 3] = st[gi];
        end
    endgenerate

    assign cmd_o     = cmd;
    assign bank_o    = s_ba;
    assign illegal_o = illegal;

    // An accepted auto refresh puts every bank into refresh.
    assert_refresh_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_AREF && !illegal_o) |=> (bank_state_o == {NUM_BANKS{BK_REF}}));

    // An accepted activate opens the named bank.
    assert_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && !illegal_o) |=> st[$past(bank_o)] == BK_OPEN);

    // An illegal activate leaves an idle bank idle.
    assert_illegal_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && illegal_o && st[bank_o] == BK_IDLE)
        |=> st[$past(bank_o)] == BK_IDLE);

endmodule

// File: tb/dram_cmd_tracker_tb.sv
// Directed bench for dram_cmd_tracker: one task per scenario.
module dram_cmd_tracker_tb;

    localparam int T_RCD = 3, T_RP = 3, T_RFC = 6, T_WR = 3, BURST_LEN = 8;

    localparam logic [3:0] C_DESEL = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
        C_RDA = 4'd4, C_WR = 4'd5, C_WRA = 4'd6, C_PRE = 4'd7, C_PREALL = 4'd8,
        C_AREF = 4'd9, C_SREF = 4'd10, C_MRS = 4'd11, C_PDN = 4'd12, C_HOLD = 4'd13;
    localparam logic [2:0] S_IDLE = 3'd0, S_OPEN = 3'd1, S_ACT = 3'd2, S_RD = 3'd3,
        S_WR = 3'd4, S_WREC = 3'd5, S_CLOSE = 3'd6, S_REF = 3'd7;
    localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100, P_PRE = 3'b010,
        P_REF = 3'b001, P_MRS = 3'b000, P_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst_n, cs_n, ras_n, cas_n, we_n, cke, a10;
    logic [2:0]  ba;
    logic [3:0]  cmd_o;
    logic [2:0]  bank_o;
    logic        illegal_o;
    logic [23:0] bank_state_o;
    int vectors = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_cmd_tracker #(.BA_W(3), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
                       .T_WR(T_WR), .BURST_LEN(BURST_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_o(bank_o),
        .illegal_o(illegal_o), .bank_state_o(bank_state_o)
    );

    // Drive one command, let it be sampled, return at the following falling edge.
    task automatic send(input logic cs, input logic [2:0] p, input logic ck,
                        input logic [2:0] b, input logic a);
        cs_n = cs; {ras_n, cas_n, we_n} = p; cke = ck; ba = b; a10 = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();
        send(1'b0, P_NOP, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic chk_cmd(input logic [3:0] ec, input logic ei, input string tag);
        vectors++;
        if (cmd_o !== ec || illegal_o !== ei) begin
            fails++;
            $display("FAIL %s: cmd=%0d illegal=%0b, expected cmd=%0d illegal=%0b",
                     tag, cmd_o, illegal_o, ec, ei);
        end
    endtask

    task automatic chk_bank(input int b, input logic [2:0] es, input string tag);
        vectors++;
        if (bank_state_o[3*b +: 3] !== es) begin
            fails++;
            $display("FAIL %s: bank%0d state=%0d, expected %0d",
                     tag, b, bank_state_o[3*b +: 3], es);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = P_NOP; cke = 1'b1; ba = '0; a10 = 1'b0;
        repeat (3) @(negedge clk);
        chk_cmd(C_DESEL, 1'b0, "R12 reset output");
        vectors++;
        if (bank_state_o !== 24'd0) begin
            fails++;
            $display("FAIL R12 reset banks: state=%h, expected %h", bank_state_o, 24'd0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_decode();
        send(1'b1, P_MRS, 1'b1, 3'd3, 1'b1);  chk_cmd(C_DESEL, 1'b0, "R2 deselect ignores pins");
        nop();                                 chk_cmd(C_NOP, 1'b0, "R1 no-op");
        send(1'b0, P_MRS, 1'b1, 3'd0, 1'b0);  chk_cmd(C_MRS, 1'b0, "R1 R8 mode write all idle");
        send(1'b0, P_RD, 1'b1, 3'd0, 1'b0);   chk_cmd(C_RD, 1'b1, "R5 read on idle bank");
        send(1'b0, P_WR, 1'b1, 3'd0, 1'b1);   chk_cmd(C_WRA, 1'b1, "R5 R3 write on idle bank");
        send(1'b0, P_PRE, 1'b1, 3'd4, 1'b0);  chk_cmd(C_PRE, 1'b0, "R5 precharge idle bank");
        nop();
        chk_bank(0, S_IDLE, "R11 illegal read kept bank idle");
        chk_bank(4, S_IDLE, "R5 precharge on idle is no-op");
    endtask

    task automatic t_read_path();
        send(1'b0, P_ACT, 1'b1, 3'd2, 1'b0);  chk_cmd(C_ACT, 1'b0, "R5 activate idle bank");
        nop();                                 chk_bank(2, S_OPEN, "R5 bank activating");
        send(1'b0, P_RD, 1'b1, 3'd2, 1'b0);   chk_cmd(C_RD, 1'b1, "R5 read before T_RCD");
        send(1'b0, P_RD, 1'b1, 3'd2, 1'b0);   chk_cmd(C_RD, 1'b0, "R5 R6 read at T_RCD");
        send(1'b0, P_RD, 1'b1, 3'd2, 1'b0);   chk_cmd(C_RD, 1'b0, "R9 read interrupts read");
        send(1'b0, P_WR, 1'b1, 3'd2, 1'b0);   chk_cmd(C_WR, 1'b1, "R9 write during read");
        nop(); nop();                          chk_bank(2, S_RD, "R10 read burst holds");
        nop();                                 chk_bank(2, S_ACT, "R10 read burst ends");
        send(1'b0, P_REF, 1'b1, 3'd0, 1'b0);  chk_cmd(C_AREF, 1'b1, "R6 R8 refresh with bank open");
        send(1'b0, P_MRS, 1'b1, 3'd0, 1'b0);  chk_cmd(C_MRS, 1'b1, "R6 mode write with bank open");
        send(1'b0, P_PRE, 1'b1, 3'd5, 1'b1);  chk_cmd(C_PREALL, 1'b0, "R3 R7 precharge-all");
        nop();                                 chk_bank(2, S_CLOSE, "R7 bank precharging");
        send(1'b0, P_ACT, 1'b1, 3'd2, 1'b0);  chk_cmd(C_ACT, 1'b1, "R7 activate while precharging");
        nop();                                 chk_bank(2, S_IDLE, "R7 idle after T_RP");
    endtask

    task automatic t_write_path();
        send(1'b0, P_ACT, 1'b1, 3'd5, 1'b0);  nop(); nop();
        send(1'b0, P_WR, 1'b1, 3'd5, 1'b0);   chk_cmd(C_WR, 1'b0, "R6 write on active bank");
        send(1'b0, P_RD, 1'b1, 3'd5, 1'b0);   chk_cmd(C_RD, 1'b1, "R9 read during write");
        send(1'b0, P_WR, 1'b1, 3'd5, 1'b1);   chk_cmd(C_WRA, 1'b0, "R9 R3 write interrupts write");
        nop(); nop(); nop();                   chk_bank(5, S_WR, "R10 write burst holds");
        nop();                                 chk_bank(5, S_WREC, "R10 write recovery");
        nop(); nop(); nop();                   chk_bank(5, S_CLOSE, "R10 auto-precharge after recovery");
        nop(); nop();                          chk_bank(5, S_CLOSE, "R10 auto-precharge holds");
        nop();                                 chk_bank(5, S_IDLE, "R10 idle after auto-precharge");
    endtask

    task automatic t_refresh();
        send(1'b0, P_REF, 1'b1, 3'd0, 1'b0);  chk_cmd(C_AREF, 1'b0, "R8 auto refresh all idle");
        nop();
        chk_bank(0, S_REF, "R8 bank0 refreshing");
        chk_bank(7, S_REF, "R8 bank7 refreshing");
        send(1'b0, P_ACT, 1'b1, 3'd3, 1'b0);  chk_cmd(C_ACT, 1'b1, "R8 activate during refresh");
        nop(); nop(); nop();                   chk_bank(3, S_REF, "R8 refresh holds");
        nop();                                 chk_bank(3, S_IDLE, "R8 idle after T_RFC");
    endtask

    task automatic t_cke();
        send(1'b0, P_REF, 1'b0, 3'd0, 1'b0);  chk_cmd(C_SREF, 1'b0, "R4 self-refresh entry");
        send(1'b0, P_NOP, 1'b0, 3'd0, 1'b0);  chk_cmd(C_HOLD, 1'b0, "R4 hold while cke low");
        send(1'b0, P_NOP, 1'b1, 3'd0, 1'b0);  chk_cmd(C_HOLD, 1'b0, "R4 hold at exit");
        nop();                                 chk_cmd(C_NOP, 1'b0, "R4 normal after exit");
        send(1'b0, P_ACT, 1'b1, 3'd1, 1'b0);
        send(1'b1, P_NOP, 1'b0, 3'd0, 1'b0);  chk_cmd(C_PDN, 1'b1, "R4 R8 power-down with bank open");
        nop();
        nop();                                 chk_bank(1, S_ACT, "R5 bank1 active");
        send(1'b0, P_ACT, 1'b0, 3'd3, 1'b0);  chk_cmd(C_ACT, 1'b1, "R4 activate while cke falls");
        nop();                                 chk_bank(3, S_IDLE, "R11 illegal activate no effect");
        send(1'b0, P_PRE, 1'b1, 3'd1, 1'b0);
        nop(); nop(); nop();                   chk_bank(1, S_IDLE, "R7 single precharge to idle");
    endtask

    task automatic t_multi_bank();
        send(1'b0, P_ACT, 1'b1, 3'd0, 1'b0);
        send(1'b0, P_ACT, 1'b1, 3'd6, 1'b0);  chk_cmd(C_ACT, 1'b0, "R5 second bank activate");
        send(1'b0, P_PRE, 1'b1, 3'd6, 1'b0);  chk_cmd(C_PRE, 1'b1, "R7 precharge while activating");
        nop(); nop();
        send(1'b0, P_PRE, 1'b1, 3'd0, 1'b0);  chk_cmd(C_PRE, 1'b0, "R3 single-bank precharge");
        nop();
        chk_bank(0, S_CLOSE, "R3 named bank closing");
        chk_bank(6, S_ACT, "R3 other bank stays open");
        send(1'b0, P_PRE, 1'b1, 3'd0, 1'b1);  chk_cmd(C_PREALL, 1'b0, "R7 precharge-all with bank closing");
        nop();                                 chk_bank(6, S_CLOSE, "R7 precharge-all closes open bank");
        nop(); nop();                          chk_bank(6, S_IDLE, "R7 idle after precharge-all");
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        t_decode();
        t_read_path();
        t_write_path();
        t_refresh();
        t_cke();
        t_multi_bank();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule